// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer ratio. It serves as the feedback divider of a frequency synthesizer. The ratio is not counted by one long modulo counter. A prescaler divides by 16 or by 17, and two slower counters steer it: a 4-bit swallow counter and an 11-bit main counter. Only the prescaler has to run at the full input rate, and the two counters only step once per prescaler period.

The ratio word is 15 bits wide. Its upper eleven bits give the main count M and its lower four bits give the swallow count A, so the division ratio is 16*M + A. A one-cycle load strobe captures a new word at any time. The counters take up the captured value only when the current output cycle ends, so an output period is never cut short. Any word below 240 is treated as 240, which keeps M >= A.

The block has two outputs. One is a one-clock divided pulse. The other is a half-rate square wave that changes level on each of those pulses, for viewing on a test port.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fpd` and `fpd_half` are both 0.
- R2: For a ratio word W in 240..32767, with M = W[14:4] and A = W[3:0], the rising edges of `fpd` are exactly 16*M + A input clocks apart.
- R3: A ratio word below 240, including 0, gives an output period of 240 clocks.
- R4: A word loaded partway through an output cycle does not change that cycle's length. It sets the length of the cycle that follows.
- R5: `fpd` is high for exactly one input clock per output cycle.
- R6: `fpd_half` changes level on the clock where `fpd` goes high and at no other time.
- R7: Within each output cycle the prescaler runs A periods of 17 clocks and then M - A periods of 16 clocks. Raising A by one at a fixed M lengthens the output period by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_word | input | 15 | Requested division ratio, bit 14 most significant |
| ratio_load | input | 1 | One-cycle strobe that captures `ratio_word` |
| fpd | output | 1 | Divided output pulse, one clock wide |
| fpd_half | output | 1 | Square wave at half the divided rate |

## Verification
Each internal fault shows up at the ports within one output period. A miscounted prescaler period, or a swallow counter that is reloaded or decremented wrongly, moves the next `fpd` edge by a few clocks. Sweeping every swallow value at a fixed main count catches such faults to the single clock. A reload taken at the wrong boundary shows as a period of the wrong length in the cycle that contains the load or in the cycle after it. A fault in the clamp shows on the first period after a small word is loaded.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  localparam int unsigned SWD_PS_BITS = 4;
  localparam int unsigned SWD_MC_BITS = 11;

  // Smallest ratio for which the main count can never fall below the swallow count
  function automatic int unsigned min_ratio(input int unsigned ps_bits);
    return (2 ** ps_bits) * ((2 ** ps_bits) - 1);
  endfunction

  // Total divide ratio produced by a main count m and swallow count a
  function automatic int unsigned total_ratio(input int unsigned ps_bits,
                                              input int unsigned m,
                                              input int unsigned a);
    return m * (2 ** ps_bits) + a;
  endfunction

endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned PS_BITS = swdiv_pkg::SWD_PS_BITS
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic swallow_on,
  output logic pre_tc
);
  localparam int unsigned PCW = PS_BITS + 1;
  localparam logic [PCW-1:0] LAST_LO = PCW'((2 ** PS_BITS) - 1);
  localparam logic [PCW-1:0] LAST_HI = PCW'(2 ** PS_BITS);

  logic [PCW-1:0] phase_q;

  // Period ends on count 15 (modulus 16) or count 16 (modulus 17)
  assign pre_tc = (phase_q == (swallow_on ? LAST_HI : LAST_LO));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (pre_tc) phase_q <= '0;
    else             phase_q <= phase_q + PCW'(1);
  end
endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters #(
  parameter int unsigned PS_BITS     = swdiv_pkg::SWD_PS_BITS,
  parameter int unsigned MC_BITS     = swdiv_pkg::SWD_MC_BITS,
  parameter int unsigned RESET_RATIO = swdiv_pkg::min_ratio(PS_BITS)
) (
  input  logic                       clk_in,
  input  logic                       rst_n,
  input  logic                       pre_tc,
  input  logic [PS_BITS+MC_BITS-1:0] next_ratio,
  output logic                       swallow_on,
  output logic                       cyc_end,
  output logic [PS_BITS-1:0]         a_cnt,
  output logic [MC_BITS-1:0]         m_cnt
);
  localparam int unsigned RW = PS_BITS + MC_BITS;
  localparam logic [RW-1:0] RST_W = RW'(RESET_RATIO);

  assign swallow_on = (a_cnt != '0);
  assign cyc_end    = pre_tc && (m_cnt == MC_BITS'(1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= RST_W[PS_BITS-1:0];
      m_cnt <= RST_W[RW-1:PS_BITS];
    end else if (cyc_end) begin
      a_cnt <= next_ratio[PS_BITS-1:0];
      m_cnt <= next_ratio[RW-1:PS_BITS];
    end else if (pre_tc) begin
      m_cnt <= m_cnt - MC_BITS'(1);
      if (swallow_on) a_cnt <= a_cnt - PS_BITS'(1);
    end
  end
endmodule

// File: rtl/swdiv_ratio_hold.sv
module swdiv_ratio_hold #(
  parameter int unsigned RW          = swdiv_pkg::SWD_PS_BITS + swdiv_pkg::SWD_MC_BITS,
  parameter int unsigned MIN_RATIO   = swdiv_pkg::min_ratio(swdiv_pkg::SWD_PS_BITS),
  parameter int unsigned RESET_RATIO = MIN_RATIO
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          ratio_load,
  input  logic [RW-1:0] ratio_word,
  output logic [RW-1:0] ratio_q
);
  localparam logic [RW-1:0] FLOOR = RW'(MIN_RATIO);

  logic [RW-1:0] clamped;
  assign clamped = (ratio_word < FLOOR) ? FLOOR : ratio_word;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)          ratio_q <= RW'(RESET_RATIO);
    else if (ratio_load) ratio_q <= clamped;
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned PS_BITS = swdiv_pkg::SWD_PS_BITS,
  parameter int unsigned MC_BITS = swdiv_pkg::SWD_MC_BITS
) (
  input  logic                       clk_in,
  input  logic                       rst_n,
  input  logic [PS_BITS+MC_BITS-1:0] ratio_word,
  input  logic                       ratio_load,
  output logic                       fpd,
  output logic                       fpd_half
);
  localparam int unsigned RW        = PS_BITS + MC_BITS;
  localparam int unsigned MIN_RATIO = swdiv_pkg::min_ratio(PS_BITS);

  // Internal events brought out for the checker
  logic               pre_tc;
  logic               swallow_on;
  logic               cyc_end;
  logic [PS_BITS-1:0] a_cnt;
  logic [MC_BITS-1:0] m_cnt;
  logic [RW-1:0]      ratio_q;

  swdiv_ratio_hold #(.RW(RW), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(MIN_RATIO)) u_hold (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_load(ratio_load),
    .ratio_word(ratio_word), .ratio_q(ratio_q)
  );

  swdiv_prescaler #(.PS_BITS(PS_BITS)) u_pre (
    .clk_in(clk_in), .rst_n(rst_n), .swallow_on(swallow_on), .pre_tc(pre_tc)
  );

  swdiv_counters #(.PS_BITS(PS_BITS), .MC_BITS(MC_BITS), .RESET_RATIO(MIN_RATIO)) u_cnt (
    .clk_in(clk_in), .rst_n(rst_n), .pre_tc(pre_tc), .next_ratio(ratio_q),
    .swallow_on(swallow_on), .cyc_end(cyc_end), .a_cnt(a_cnt), .m_cnt(m_cnt)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      fpd      <= 1'b0;
      fpd_half <= 1'b0;
    end else begin
      fpd <= cyc_end;
      if (cyc_end) fpd_half <= ~fpd_half;
    end
  end
endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
  parameter int unsigned PS_BITS = 4,
  parameter int unsigned MC_BITS = 11
) (
  input logic                       clk_in,
  input logic                       rst_n,
  input logic                       fpd,
  input logic                       fpd_half,
  input logic                       pre_tc,
  input logic [PS_BITS-1:0]         a_cnt,
  input logic [MC_BITS-1:0]         m_cnt,
  input logic [PS_BITS+MC_BITS-1:0] ratio_q
);
  localparam int unsigned RW   = PS_BITS + MC_BITS;
  localparam int unsigned GW   = PS_BITS + 2;
  localparam int unsigned MINR = swdiv_pkg::min_ratio(PS_BITS);

  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (pre_tc) gap_q <= '0;
    else             gap_q <= gap_q + GW'(1);
  end

  // R7: every prescaler period lasts 16 or 17 clocks
  a_r7_modulus: assert property (@(posedge clk_in) disable iff (!rst_n)
    pre_tc |-> (gap_q == GW'((2 ** PS_BITS) - 1) || gap_q == GW'(2 ** PS_BITS)));

  // R7: swallow count never exceeds the remaining main count
  a_r7_swallow_fits: assert property (@(posedge clk_in) disable iff (!rst_n)
    (MC_BITS'(a_cnt) <= m_cnt) && (m_cnt != '0));

  // R3: held ratio never below the floor
  a_r3_floor: assert property (@(posedge clk_in) disable iff (!rst_n)
    ratio_q >= RW'(MINR));

  // R5: output pulse one clock wide
  a_r5_single_pulse: assert property (@(posedge clk_in) disable iff (!rst_n)
    fpd |=> !fpd);

  // R6: half-rate output changes with the pulse
  a_r6_toggle_on_pulse: assert property (@(posedge clk_in) disable iff (!rst_n)
    fpd |-> (fpd_half != $past(fpd_half)));

  // R6: and at no other time
  a_r6_hold_between: assert property (@(posedge clk_in) disable iff (!rst_n)
    !fpd |-> $stable(fpd_half));
endmodule

bind swallow_divider swdiv_checker #(.PS_BITS(PS_BITS), .MC_BITS(MC_BITS)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .fpd(fpd), .fpd_half(fpd_half),
  .pre_tc(pre_tc), .a_cnt(a_cnt), .m_cnt(m_cnt), .ratio_q(ratio_q)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;
  logic        clk_in = 1'b0;
  logic        rst_n  = 1'b0;
  logic [14:0] ratio_word = '0;
  logic        ratio_load = 1'b0;
  logic        fpd, fpd_half;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int cur   = 240;
  logic exp_half = 1'b0;
  logic prev_half = 1'b0;
  int   wide_pulse = 0;
  int   stray_toggle = 0;
  int   bad_half = 0;

  always #10 clk_in = ~clk_in;

  swallow_divider i_swallow_divider (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_word(ratio_word),
    .ratio_load(ratio_load), .fpd(fpd), .fpd_half(fpd_half)
  );

  always @(posedge clk_in) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_ratio(input int w);
    int m, a;
    if (w < 240) w = 240;
    m = w / 16;
    a = w % 16;
    return 16 * m + a;
  endfunction

  // Count negedges until fpd is seen high; optionally strobe a load after 'dly' samples
  task automatic measure(output int n, input int dly, input bit do_load, input int w);
    n = 0;
    forever begin
      if (n == dly && do_load) begin
        ratio_word = 15'(w);
        ratio_load = 1'b1;
      end
      @(negedge clk_in);
      ratio_load = 1'b0;
      n++;
      if (n == 1 && fpd) wide_pulse++;
      if (!fpd && fpd_half != prev_half) stray_toggle++;
      prev_half = fpd_half;
      if (fpd && n > 1) begin
        exp_half = ~exp_half;
        if (fpd_half != exp_half) bad_half++;
        break;
      end
      if (n > 40000) break;
    end
  endtask

  task automatic step(input int w, input int dly, input string tag);
    int n1, n2, e;
    e = eff_ratio(w);
    measure(n1, dly, 1'b1, w);
    check(n1 == cur, $sformatf("R4 %s old period kept (w=%0d)", tag, w), n1, cur);
    measure(n2, 0, 1'b0, 0);
    check(n2 == e, $sformatf("%s period (w=%0d)", tag, w), n2, e);
    cur = e;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk_in);
    check(1'b0, "watchdog expired", cyc, 190000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_in);
    check(fpd == 1'b0, "R1 fpd in reset", fpd, 0);
    check(fpd_half == 1'b0, "R1 fpd_half in reset", fpd_half, 0);
    rst_n = 1'b1;
    @(negedge clk_in);
    check(fpd == 1'b0 && fpd_half == 1'b0, "R1 outputs after release", {fpd, fpd_half}, 0);
    prev_half = fpd_half;
    measure(n, 0, 1'b0, 0);   // align to first pulse

    // R3: words below the floor
    step(0,   0, "R3 clamp");
    step(100, 5, "R3 clamp");
    step(239, 9, "R3 clamp");
    // R2: sweep upward from the floor
    for (int w = 240; w < 272; w++) step(w, 2, "R2 sweep");
    // R7: all swallow values at M = 20
    for (int a = 0; a < 16; a++) step(20 * 16 + a, 3, "R7 swallow");
    // R2 / R4: large ratios with late loads
    step(1000, 150, "R2 mid");
    step(4095, 900, "R4 late load");
    step(32767, 10, "R2 max");
    step(240, 30000, "R4 late load");

    check(wide_pulse == 0, "R5 pulse width", wide_pulse, 0);
    check(stray_toggle == 0, "R6 stray toggles", stray_toggle, 0);
    check(bad_half == 0, "R6 toggle on pulse", bad_half, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule